// File: doc/BRIEF.md
# Glitch-free five-way clock source selector

This block picks one of five free-running input clocks and drives it onto a single domain clock output. Software chooses the source by writing a 3-bit index. When the index changes, the block first shuts off the current source, waits until that shutdown has been confirmed back in the register clock domain, and only then opens the new source. Each source has its own gate. A gate closes or opens only while its own clock is low, so the output never carries a shortened pulse.

A status bit reads high from the cycle after an accepted write until the new source is confirmed running. Software polls this bit to know when the handover is over. A write that arrives during a handover is kept and applied as soon as the running handover ends. Index values with no source behind them are dropped. A build-time option locks the selector to the highest source. In that build, writes have no effect and the index always reads back as 4. All control and status pins are plain, single-cycle signals with no handshake.

Top module: `clk_src_switch`

## Requirements
- R1: After reset, `cfg_rdata_o` reads 4'b0001 (index 1, status bit clear) and `clk_o` follows `src_clk_i[1]`. In the locked build it reads 4'b0100 and follows `src_clk_i[4]`.
- R2: Writing index i (0..4) through `cfg_wsel_i` with `cfg_we_i` high makes `clk_o` follow `src_clk_i[i]` once the handover ends, and `cfg_rdata_o[2:0]` reads i.
- R3: `cfg_rdata_o[3]` (busy) is 1 in the `clk_i` cycle after a write that selects a different valid source.
- R4: Busy clears only after the new source's synchronised enable is seen high in the `clk_i` domain. From that cycle on, `clk_o` equals the new source.
- R5: The new source's enable is not requested until every source's enable is seen low. During a handover, `clk_o` is high only while the old or new source is high, and it stays low for at least 3 `clk_i` cycles between the two.
- R6: A written index of 5, 6 or 7 is ignored: busy stays 0, the index read back is unchanged, and `clk_o` keeps its source.
- R7: Writing the index that is already active starts no handover: busy stays 0 and `clk_o` keeps its source.
- R8: A valid write accepted while busy is held. Once the running handover completes, the block switches to the last such index, and busy stays high until that switch is done.
- R9: In the locked build, writes have no effect: busy never rises, `cfg_rdata_o[2:0]` reads 4, and `clk_o` follows `src_clk_i[4]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Register-side clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_clk_i | input | 5 | Candidate clocks: 0 slow crystal, 1 main oscillator, 2..4 synthesised clocks |
| cfg_we_i | input | 1 | Write strobe for the source index |
| cfg_wsel_i | input | 3 | Source index written |
| cfg_rdata_o | output | 4 | Bit 3 busy, bits 2:0 source index |
| clk_o | output | 1 | Selected domain clock |

## Verification
The assertions assume that every source clock keeps toggling while its gate is being opened or closed. A stopped source would stall the handshake, and the busy bit would then stay high. They also assume that reset is applied through `rst_ni` and not mid-edge on a source. The stimulus keeps all five sources running at fixed rates and offsets their edges from the `clk_i` edges so that no sample falls on a transition. Writes are driven only between `clk_i` edges.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;
  typedef enum logic [1:0] {
    SW_IDLE  = 2'd0,
    SW_DROP  = 2'd1,
    SW_RAISE = 2'd2
  } sw_state_e;
endpackage

// File: rtl/clksw_sync.sv
`timescale 1ns/1ps
module clksw_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST;
      sync_q <= RST;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/clksw_leg.sv
`timescale 1ns/1ps
module clksw_leg #(
  parameter bit RST_ON = 1'b0
) (
  input  logic src_clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic ack_o,
  output logic gclk_o
);
  logic en_s;
  logic en_low_q;

  clksw_sync #(.W(1), .RST(RST_ON)) u_en_sync (
    .clk_i (src_clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_i),
    .q_o   (en_s)
  );

  // gate changes only on the falling edge, while the source is low
  always_ff @(negedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) en_low_q <= RST_ON;
    else         en_low_q <= en_s;
  end

  assign gclk_o = src_clk_i & en_low_q;
  assign ack_o  = en_low_q;
endmodule

// File: rtl/clksw_ctrl.sv
`timescale 1ns/1ps
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int unsigned NSRC    = 5,
  parameter int unsigned RST_SEL = 1,
  parameter bit          LOCKED  = 1'b0,
  localparam int unsigned SEL_W  = $clog2(NSRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] wsel_i,
  input  logic [NSRC-1:0]  ack_i,
  output logic [NSRC-1:0]  req_o,
  output logic             busy_o,
  output logic [SEL_W-1:0] sel_o
);
  localparam logic [SEL_W-1:0] LAST     = SEL_W'(NSRC - 1);
  localparam logic [SEL_W-1:0] RST_CODE = SEL_W'(RST_SEL);
  localparam logic [NSRC-1:0]  ONE      = NSRC'(1);
  localparam logic [NSRC-1:0]  RST_OH   = ONE << RST_SEL;

  sw_state_e        state_q;
  logic [SEL_W-1:0] sel_q, pend_sel_q;
  logic             pend_v_q;
  logic [NSRC-1:0]  req_q, ack_s;
  logic             wr_ok, done, chain_v;
  logic [SEL_W-1:0] chain_sel;

  clksw_sync #(.W(NSRC), .RST(RST_OH)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_i),
    .q_o   (ack_s)
  );

  assign wr_ok     = we_i && !LOCKED && (wsel_i <= LAST);
  assign done      = (ack_s & req_q) != '0;
  assign chain_sel = wr_ok ? wsel_i : pend_sel_q;
  assign chain_v   = (wr_ok || pend_v_q) && (chain_sel != sel_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SW_IDLE;
      sel_q      <= RST_CODE;
      pend_sel_q <= RST_CODE;
      pend_v_q   <= 1'b0;
      req_q      <= RST_OH;
    end else begin
      unique case (state_q)
        SW_IDLE: begin
          if (wr_ok && wsel_i != sel_q) begin
            sel_q   <= wsel_i;
            req_q   <= '0;
            state_q <= SW_DROP;
          end
        end
        SW_DROP: begin
          if (wr_ok) begin
            pend_v_q   <= 1'b1;
            pend_sel_q <= wsel_i;
          end
          if (ack_s == '0) begin
            req_q   <= ONE << sel_q;
            state_q <= SW_RAISE;
          end
        end
        SW_RAISE: begin
          if (done) begin
            pend_v_q <= 1'b0;
            if (chain_v) begin
              sel_q   <= chain_sel;
              req_q   <= '0;
              state_q <= SW_DROP;
            end else begin
              state_q <= SW_IDLE;
            end
          end else if (wr_ok) begin
            pend_v_q   <= 1'b1;
            pend_sel_q <= wsel_i;
          end
        end
        default: state_q <= SW_IDLE;
      endcase
    end
  end

  assign req_o  = req_q;
  assign busy_o = (state_q != SW_IDLE);
  assign sel_o  = pend_v_q ? pend_sel_q : sel_q;

  // R3: an accepted change raises busy in the next cycle
  a_r3_busy_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && wr_ok && wsel_i != sel_q) |=> busy_o);
  // R6: an out-of-range index starts nothing
  a_r6_invalid_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && we_i && wsel_i > LAST) |=> !busy_o);
  // R5: at most one source requested at any time
  a_r5_single_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_q));
  // R5: a new request appears only after all enables were seen low
  a_r5_break_before_make: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q != '0 && $past(req_q) == '0) |-> $past(ack_s) == '0);
  // R4: busy falls only once the requested source reports enabled
  a_r4_done_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past((ack_s & req_q) != '0));
  // R9: the locked build never starts a handover
  a_r9_locked_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    LOCKED |-> (!busy_o && req_q == RST_OH));
endmodule

// File: rtl/clk_src_switch.sv
`timescale 1ns/1ps
module clk_src_switch #(
  parameter int unsigned NUM_SRC    = 5,
  parameter int unsigned BOOT_SRC   = 1,
  parameter bit          FIXED_PLL3 = 1'b0,
  localparam int unsigned SEL_W     = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_clk_i,
  input  logic               cfg_we_i,
  input  logic [SEL_W-1:0]   cfg_wsel_i,
  output logic [SEL_W:0]     cfg_rdata_o,
  output logic               clk_o
);
  localparam int unsigned START = FIXED_PLL3 ? (NUM_SRC - 1) : BOOT_SRC;

  logic [NUM_SRC-1:0] req, ack, gclk;
  logic               busy;
  logic [SEL_W-1:0]   sel;

  clksw_ctrl #(
    .NSRC   (NUM_SRC),
    .RST_SEL(START),
    .LOCKED (FIXED_PLL3)
  ) u_ctrl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (cfg_we_i),
    .wsel_i(cfg_wsel_i),
    .ack_i (ack),
    .req_o (req),
    .busy_o(busy),
    .sel_o (sel)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_leg
    clksw_leg #(.RST_ON(i == START)) u_leg (
      .src_clk_i(src_clk_i[i]),
      .rst_ni   (rst_ni),
      .req_i    (req[i]),
      .ack_o    (ack[i]),
      .gclk_o   (gclk[i])
    );
  end

  assign clk_o       = |gclk;
  assign cfg_rdata_o = {busy, FIXED_PLL3 ? SEL_W'(NUM_SRC - 1) : sel};
endmodule

// File: tb/clk_src_switch_test.sv
`timescale 1ns/1ps
module clk_src_switch_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic s0 = 1'b0, s1 = 1'b0, s2 = 1'b0, s3 = 1'b0, s4 = 1'b0;
  logic [4:0] src;
  logic we = 1'b0, we_f = 1'b0;
  logic [2:0] wsel = '0, wsel_f = '0;
  logic [3:0] rd, rd_f;
  logic co, co_f;
  int total = 0, bad = 0, cyc = 0;
  bit fin_done = 1'b0;

  // entry: {write index, expected source, handover expected}
  localparam logic [6:0] VEC [10] = '{
    {3'd2, 3'd2, 1'b1}, {3'd0, 3'd0, 1'b1}, {3'd3, 3'd3, 1'b1},
    {3'd4, 3'd4, 1'b1}, {3'd1, 3'd1, 1'b1}, {3'd6, 3'd1, 1'b0},
    {3'd5, 3'd1, 1'b0}, {3'd1, 3'd1, 1'b0}, {3'd7, 3'd1, 1'b0},
    {3'd2, 3'd2, 1'b1}};

  always #2 clk = ~clk;
  initial begin #0.3; forever #20 s0 = ~s0; end
  initial begin #0.3; forever #5  s1 = ~s1; end
  initial begin #0.3; forever #3  s2 = ~s2; end
  initial begin #0.3; forever #7  s3 = ~s3; end
  initial begin #0.3; forever #4  s4 = ~s4; end
  assign src = {s4, s3, s2, s1, s0};

  clk_src_switch uut (
    .clk_i(clk), .rst_ni(rst_n), .src_clk_i(src),
    .cfg_we_i(we), .cfg_wsel_i(wsel), .cfg_rdata_o(rd), .clk_o(co));

  clk_src_switch #(.FIXED_PLL3(1'b1)) uut_fix (
    .clk_i(clk), .rst_ni(rst_n), .src_clk_i(src),
    .cfg_we_i(we_f), .cfg_wsel_i(wsel_f), .cfg_rdata_o(rd_f), .clk_o(co_f));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input bit fx, input logic [2:0] v);
    @(negedge clk);
    if (fx) begin we_f = 1'b1; wsel_f = v; end
    else    begin we = 1'b1;   wsel = v;   end
    @(negedge clk);
    we = 1'b0; we_f = 1'b0;
  endtask

  task automatic follow(input bit fx, input int idx, input string tag);
    int mis = 0;
    repeat (150) begin
      @(negedge clk);
      if ((fx ? co_f : co) !== src[idx]) mis++;
    end
    chk(mis == 0, tag, mis, 0);
  endtask

  task automatic wait_idle(input logic [4:0] mask, output int gap, output int illegal);
    int run = 0;
    gap = 0; illegal = 0;
    for (int k = 0; k < 3000; k++) begin
      if (!rd[3]) break;
      if (co && ((src & mask) == '0)) illegal++;
      if (!co) run++;
      else begin
        if (run > gap) gap = run;
        run = 0;
      end
      @(negedge clk);
    end
    if (run > gap) gap = run;
    chk(rd[3] == 1'b0, "R4 handover completes", int'(rd[3]), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !fin_done) begin
      fin_done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int gap, ill, cur;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state of both builds
    chk(rd == 4'b0001, "R1 reset readback", int'(rd), 1);
    follow(1'b0, 1, "R1 reset source");
    chk(rd_f == 4'b0100, "R1 locked reset readback", int'(rd_f), 4);
    follow(1'b1, 4, "R1 locked reset source");

    cur = 1;
    for (int i = 0; i < 10; i++) begin
      logic [2:0] ws, ex;
      logic sw;
      {ws, ex, sw} = VEC[i];
      wr(1'b0, ws);
      if (sw) begin
        chk(rd[3] == 1'b1, "R3 busy after write", int'(rd[3]), 1);
        wait_idle((5'b1 << cur) | (5'b1 << ex), gap, ill);
        chk(ill == 0, "R5 only old/new pulses", ill, 0);
        chk(gap >= 3, "R5 low gap", gap, 3);
        chk(rd == {1'b0, ex}, "R2 readback", int'(rd), int'(ex));
        follow(1'b0, int'(ex), "R2 output source");
      end else if (ws > 3'd4) begin
        chk(rd == {1'b0, ex}, "R6 invalid ignored readback", int'(rd), int'(ex));
        follow(1'b0, int'(ex), "R6 invalid keeps source");
      end else begin
        chk(rd[3] == 1'b0, "R7 same index no busy", int'(rd[3]), 0);
        follow(1'b0, int'(ex), "R7 same index keeps source");
      end
      cur = int'(ex);
    end

    // R8: write during a handover is held, the last one wins
    wr(1'b0, 3'd3);
    wr(1'b0, 3'd4);
    wr(1'b0, 3'd0);
    chk(rd[3] == 1'b1, "R8 busy during chain", int'(rd[3]), 1);
    wait_idle(5'b11101, gap, ill);
    chk(ill == 0, "R8 chain pulses legal", ill, 0);
    chk(rd == 4'b0000, "R8 final readback", int'(rd), 0);
    follow(1'b0, 0, "R8 final source");

    // R9: locked build ignores writes
    wr(1'b1, 3'd2);
    chk(rd_f == 4'b0100, "R9 locked no busy", int'(rd_f), 4);
    repeat (20) @(negedge clk);
    chk(rd_f == 4'b0100, "R9 locked readback", int'(rd_f), 4);
    follow(1'b1, 4, "R9 locked source");

    // R1: reset in mid-run returns to the main oscillator
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rd == 4'b0001, "R1 re-reset readback", int'(rd), 1);
    follow(1'b0, 1, "R1 re-reset source");

    if (!fin_done) begin
      fin_done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule